// File: doc/BRIEF.md
# Equal-Segment Approximate Adder

This block adds two N-bit operands and a carry-in without any carry chain running the full width. The operand width is cut into equal sub-adders of K bits, each an exact adder over its own span, and no sub-adder waits on another. The lowest sub-adder takes the external carry-in and reports all K of its sum bits. Every later sub-adder starts L bits below the window it reports. Those L low bits begin from a carry of zero, and they serve only to guess the carry into the window. Their own sum bits are thrown away. Result windows therefore move up by K-L bits per sub-adder. The last window is cut off at bit N-1, and its carry-out is the carry-out of the adder.

The block is purely combinational. K bounds the longest carry path, and L sets how far back each window looks to predict its incoming carry. Any pair with 1 ≤ K < N and 0 ≤ L < K is a legal configuration that needs only parameter changes. Any other pair stops elaboration with an error. Users trade accuracy against delay by picking K and L.

Top module: `eqseg_approx_adder`

## Requirements
- R1: Sum bits [K-1:0] equal the low K bits of a_i[K-1:0] + b_i[K-1:0] + cin_i. The carry-in reaches no other bit.
- R2: Sub-adder i (i ≥ 1) reports sum bits from K+(i-1)(K-L) to K+i(K-L)-1. Bits that lie below a window and do not appear in it have no effect on it except through the predicted carry.
- R3: The carry into each window after the first is the carry out of the L operand bits directly below it, added with a carry-in of 0. A carry that starts further down is lost.
- R4: With L = 0, every window after the first receives a carry of 0, so the adder acts as a set of disjoint K-bit adders.
- R5: The last window ends at bit N-1 even if this makes it shorter than K-L bits. Its carry-out drives cout_o, and a carry lost below it never reaches cout_o.
- R6: Whenever every true carry into a window start is either 0 or produced inside that window's L prediction bits, {cout_o, sum_o} equals the exact a_i + b_i + cin_i.
- R7: With b_i = 0 and cin_i = 0, sum_o equals a_i and cout_o is 0.
- R8: With a_i & b_i = 0 and cin_i = 0, sum_o equals a_i ^ b_i and cout_o is 0.
- R9: The outputs follow the inputs without any clock edge and hold no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into the lowest sub-adder |
| sum_o | output | N | Approximate sum, built from the reported window of each sub-adder |
| cout_o | output | 1 | Carry out of the last, possibly truncated, window |

## Verification
A window's own exact addition and the carry predicted for it can act on the same output bits at once. The carry either agrees with the true one or is lost. Table vectors are chosen so that a carry runs through the L prediction bits of a window, or starts below them, within a single operand pair. The result is then judged against a separate segment model and against the exact sum. A second meeting point is the truncated top window, where a lost carry and the carry-out coincide. Random pairs are also checked against the exact sum whenever the bench's propagate and generate test shows that every window's prediction was enough.

// File: rtl/eqseg_pkg.sv
package eqseg_pkg;

   // Step between the result windows of consecutive sub-adders.
   function automatic int eqseg_step(input int k, input int l);
      return (k > l) ? (k - l) : 1;
   endfunction

   // Number of sub-adders needed to cover n bits.
   function automatic int eqseg_count(input int n, input int k, input int l);
      int st;
      st = eqseg_step(k, l);
      return (n > k) ? (1 + (n - k + st - 1) / st) : 1;
   endfunction

   // Lowest reported bit of sub-adder i.
   function automatic int eqseg_lo(input int i, input int k, input int l);
      return (i == 0) ? 0 : (k + (i - 1) * eqseg_step(k, l));
   endfunction

   // Highest reported bit of sub-adder i, truncated at n-1.
   function automatic int eqseg_hi(input int i, input int n, input int k, input int l);
      int t;
      t = k - 1 + i * eqseg_step(k, l);
      return (t > n - 1) ? (n - 1) : t;
   endfunction

endpackage

// File: rtl/eqseg_carry_pred.sv
// Ripple-style carry guess over the overlap bits of one sub-adder.
module eqseg_carry_pred #(
   parameter int W = 2
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic         cout_o
);
   logic c_run;

   always_comb begin
      c_run = cin_i;
      for (int j = 0; j < W; j++) begin
         c_run = (a_i[j] & b_i[j]) | (c_run & (a_i[j] ^ b_i[j]));
      end
      cout_o = c_run;
   end
endmodule

// File: rtl/eqseg_exact_add.sv
// Exact adder over one result window; CO selects whether the carry-out is kept.
module eqseg_exact_add #(
   parameter int W  = 2,
   parameter int CO = 0
) (
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   input  logic            cin_i,
   output logic [W+CO-1:0] res_o
);
   generate
      if (CO != 0) begin : g_with_co
         assign res_o = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i);
      end else begin : g_no_co
         assign res_o = a_i + b_i + W'(cin_i);
      end
   endgenerate
endmodule

// File: rtl/eqseg_lane.sv
// One sub-adder: PL prediction bits below RW reported bits.
module eqseg_lane #(
   parameter int RW = 2,
   parameter int PL = 0,
   parameter int CO = 0
) (
   input  logic [RW+PL-1:0] a_i,
   input  logic [RW+PL-1:0] b_i,
   input  logic             cin_i,
   output logic [RW+CO-1:0] res_o
);
   logic win_c;

   generate
      if (PL > 0) begin : g_pred
         eqseg_carry_pred #(.W(PL)) u_pred (
            .a_i    (a_i[PL-1:0]),
            .b_i    (b_i[PL-1:0]),
            .cin_i  (cin_i),
            .cout_o (win_c)
         );
      end else begin : g_direct
         assign win_c = cin_i;
      end
   endgenerate

   eqseg_exact_add #(.W(RW), .CO(CO)) u_add (
      .a_i   (a_i[RW+PL-1:PL]),
      .b_i   (b_i[RW+PL-1:PL]),
      .cin_i (win_c),
      .res_o (res_o)
   );
endmodule

// File: rtl/eqseg_approx_adder.sv
module eqseg_approx_adder
   import eqseg_pkg::*;
#(
   parameter int N = 16,
   parameter int K = 4,
   parameter int L = 2
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic         cin_i,
   output logic [N-1:0] sum_o,
   output logic         cout_o
);
   localparam int NSEG = eqseg_count(N, K, L);

   // Elaboration-time legality of the configuration.
   generate
      if (K < 1 || K >= N) begin : g_bad_k
         $error("eqseg_approx_adder: K must satisfy 1 <= K < N");
      end
      if (L < 0 || L >= K) begin : g_bad_l
         $error("eqseg_approx_adder: L must satisfy 0 <= L < K");
      end
   endgenerate

   generate
      for (genvar g = 0; g < NSEG; g++) begin : g_win
         localparam int LO = eqseg_lo(g, K, L);
         localparam int HI = eqseg_hi(g, N, K, L);
         localparam int PL = (g == 0) ? 0 : L;
         localparam int RW = HI - LO + 1;

         logic lane_cin;
         if (g == 0) begin : g_first
            assign lane_cin = cin_i;           // R1: only the low lane sees cin
         end else begin : g_later
            assign lane_cin = 1'b0;            // R3/R4: prediction starts at 0
         end

         if (g == NSEG - 1) begin : g_last
            eqseg_lane #(.RW(RW), .PL(PL), .CO(1)) u_lane (
               .a_i   (a_i[HI:LO-PL]),
               .b_i   (b_i[HI:LO-PL]),
               .cin_i (lane_cin),
               .res_o ({cout_o, sum_o[HI:LO]})  // R5
            );
         end else begin : g_mid
            eqseg_lane #(.RW(RW), .PL(PL), .CO(0)) u_lane (
               .a_i   (a_i[HI:LO-PL]),
               .b_i   (b_i[HI:LO-PL]),
               .cin_i (lane_cin),
               .res_o (sum_o[HI:LO])
            );
         end
      end
   endgenerate
endmodule

// File: rtl/eqseg_approx_adder_chk.sv
module eqseg_approx_adder_chk
   import eqseg_pkg::*;
#(
   parameter int N = 16,
   parameter int K = 4,
   parameter int L = 2
) (
   input logic [N-1:0] a_i,
   input logic [N-1:0] b_i,
   input logic         cin_i,
   input logic [N-1:0] sum_o,
   input logic         cout_o
);
   localparam int NSEG = eqseg_count(N, K, L);

   always_comb begin
      a_r1_low_window_exact: assert (sum_o[K-1:0] == K'(a_i[K-1:0] + b_i[K-1:0] + K'(cin_i)))
         else $error("R1 low window mismatch");
      a_r7_passthrough: assert (!(b_i == '0 && !cin_i) || (sum_o == a_i && !cout_o))
         else $error("R7 pass-through mismatch");
      a_r8_no_generate: assert (!((a_i & b_i) == '0 && !cin_i) || (sum_o == (a_i ^ b_i) && !cout_o))
         else $error("R8 carry-free mismatch");
      a_r5_cout_top: assert ((!(a_i[N-1] & b_i[N-1]) || cout_o) && ((a_i[N-1] | b_i[N-1]) || !cout_o))
         else $error("R5 carry-out inconsistent with top bits");
   end

   // R3 and R4: a window whose prediction bits are all zero (or absent) adds with no carry.
   generate
      for (genvar g = 1; g < NSEG; g++) begin : g_w
         localparam int LO = eqseg_lo(g, K, L);
         localparam int HI = eqseg_hi(g, N, K, L);
         localparam int RW = HI - LO + 1;
         if (L == 0) begin : g_dis
            always_comb begin
               a_r4_disjoint_window: assert (sum_o[HI:LO] == RW'(a_i[HI:LO] + b_i[HI:LO]))
                  else $error("R4 disjoint window mismatch");
            end
         end else begin : g_ovl
            always_comb begin
               a_r3_quiet_prediction: assert (!(a_i[LO-1:LO-L] == '0 && b_i[LO-1:LO-L] == '0)
                                              || sum_o[HI:LO] == RW'(a_i[HI:LO] + b_i[HI:LO]))
                  else $error("R3 window with quiet prediction bits mismatch");
            end
         end
      end
   endgenerate
endmodule

bind eqseg_approx_adder eqseg_approx_adder_chk #(.N(N), .K(K), .L(L)) u_chk (.*);

// File: tb/eqseg_approx_adder_test.sv
`timescale 1ns/1ps
module eqseg_approx_adder_test;
   localparam int NW = 16;

   typedef struct packed {
      logic [NW-1:0] a;
      logic [NW-1:0] b;
      logic          cin;
      logic [NW-1:0] s;
      logic          co;
   } vec_t;

   // Configuration of uut: K=4, L=2 (windows step by 2).
   localparam vec_t VEC [12] = '{
      '{16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
      '{16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},
      '{16'h00FF, 16'h0001, 1'b0, 16'h00F0, 1'b0},
      '{16'h000C, 16'h0004, 1'b0, 16'h0010, 1'b0},
      '{16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
      '{16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},
      '{16'h1234, 16'h0000, 1'b0, 16'h1234, 1'b0},
      '{16'hA5A5, 16'h5A5A, 1'b0, 16'hFFFF, 1'b0},
      '{16'h00F0, 16'h0010, 1'b0, 16'h0000, 1'b0},
      '{16'h0030, 16'h0010, 1'b0, 16'h0040, 1'b0},
      '{16'h7FFF, 16'h0001, 1'b0, 16'h7FF0, 1'b0},
      '{16'h000F, 16'h0000, 1'b1, 16'h0000, 1'b0}
   };
   localparam string TAG [12] = '{"R1", "R1", "R2", "R3", "R6", "R5",
                                  "R7", "R8", "R3", "R6", "R2", "R1"};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NW-1:0] a = '0, b = '0;
   logic cin = 1'b0;
   logic [NW-1:0] s_m, s_d, s_o;
   logic co_m, co_d, co_o;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   eqseg_approx_adder #(.N(NW), .K(4), .L(2)) uut (
      .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_m), .cout_o(co_m));
   eqseg_approx_adder #(.N(NW), .K(5), .L(0)) uut_dis (
      .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_d), .cout_o(co_d));
   eqseg_approx_adder #(.N(NW), .K(4), .L(3)) uut_ovl (
      .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_o), .cout_o(co_o));

   // Segment-rule model: lane 0 takes cin, later lanes start l bits low with carry 0.
   function automatic logic [NW:0] model(input int k, input int l,
                                         input logic [NW-1:0] x, input logic [NW-1:0] y,
                                         input logic ci);
      logic [NW-1:0] r;
      logic c, last_c;
      int lo, hi, st, seg;
      r = '0; last_c = 1'b0; lo = 0; seg = 0;
      while (lo < NW) begin
         hi = (seg == 0) ? k - 1 : lo + (k - l) - 1;
         if (hi > NW - 1) hi = NW - 1;
         st = (seg == 0) ? 0 : lo - l;
         c  = (seg == 0) ? ci : 1'b0;
         for (int j = st; j <= hi; j++) begin
            if (j >= lo) r[j] = x[j] ^ y[j] ^ c;
            c = (x[j] & y[j]) | (c & (x[j] | y[j]));
         end
         last_c = c;
         lo = hi + 1;
         seg++;
      end
      return {last_c, r};
   endfunction

   task automatic check(input string tag, input logic [NW:0] act, input logic [NW:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%b)", tag, act, exp, a, b, cin);
      end
   endtask

   task automatic apply(input logic [NW-1:0] x, input logic [NW-1:0] y, input logic ci);
      @(posedge clk);
      a = x; b = y; cin = ci;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [NW:0] ex;
      logic [NW:0] tc;
      logic ok;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // Reset state: zero operands give zero on every configuration (R1, R7).
      check("R1 reset uut", {co_m, s_m}, '0);
      check("R7 reset uut_dis", {co_d, s_d}, '0);
      check("R7 reset uut_ovl", {co_o, s_o}, '0);
      rst = 1'b0;

      for (int i = 0; i < 12; i++) begin
         apply(VEC[i].a, VEC[i].b, VEC[i].cin);
         check(TAG[i], {co_m, s_m}, {VEC[i].co, VEC[i].s});
      end

      // Disjoint configuration K=5, L=0: windows [4:0],[9:5],[14:10],[15:15].
      apply(16'h001F, 16'h0001, 1'b0);
      check("R4 carry out of lane 0 dropped", {co_d, s_d}, 17'h00000);
      apply(16'h03E0, 16'h0020, 1'b0);
      check("R4 carry out of lane 1 dropped", {co_d, s_d}, 17'h00000);
      apply(16'h0421, 16'h0421, 1'b1);
      check("R4 no crossing carries exact", {co_d, s_d}, 17'h00843);
      apply(16'h4000, 16'h4000, 1'b0);
      check("R5 truncated top lane gets no carry", {co_d, s_d}, 17'h00000);
      apply(16'h8000, 16'h8000, 1'b0);
      check("R5 truncated top lane drives cout", {co_d, s_d}, 17'h10000);

      // R9: change inputs in the low clock phase, sample before any edge.
      @(negedge clk);
      a = 16'h1234; b = 16'h0001; cin = 1'b0;
      #0.5;
      check("R9 settles without clock", {co_m, s_m}, 17'h01235);

      // Random operands against the segment model and the exact sum.
      for (int i = 0; i < 400; i++) begin
         apply(NW'($urandom), NW'($urandom), 1'($urandom));
         check("R2 model uut",     {co_m, s_m}, model(4, 2, a, b, cin));
         check("R4 model uut_dis", {co_d, s_d}, model(5, 0, a, b, cin));
         check("R3 model uut_ovl", {co_o, s_o}, model(4, 3, a, b, cin));
         // R6: when each window start's true carry is 0 or born in its 2 prediction bits.
         ex = {1'b0, a} + {1'b0, b} + (NW+1)'(cin);
         tc = {1'b0, a ^ b} ^ ex;
         ok = 1'b1;
         for (int p = 4; p < NW; p += 2) begin
            if (tc[p] && tc[p-2] && (a[p-1] ^ b[p-1]) && (a[p-2] ^ b[p-2])) ok = 1'b0;
         end
         if (ok) check("R6 exact when prediction suffices", {co_m, s_m}, ex);
      end

      finish_run();
   end
endmodule